// File: doc/BRIEF.md
# Subcarrier edge-count bit receiver

This block turns the output of an amplitude comparator into response bits from a contactless tag. While the tag answers with a one, its subcarrier makes the comparator toggle about forty times per bit period. A zero leaves the comparator still. After a start trigger the block waits a fixed turnaround time and then cuts time into back-to-back bit windows of fixed length. It counts the comparator level changes in each window and compares that count with a threshold.

The link carries no frame delimiters, and an all-zero answer cannot be told apart from silence. The caller therefore gives the number of bits to collect, and bits are packed LSB-first. A second mode collects nothing. It scans a bounded number of windows for a single one-bit that acknowledges a write, and reports the index of the window where that bit was found, or a timeout. One clock cycle is one timing tick.

Top module: `edge_count_rx`

## Requirements
- R1: After reset, `busy`, `done`, `bad_len`, `ack_hit` and `ack_timeout` are low and `rx_word` is zero.
- R2: A start accepted at clock edge k opens window 0 at edge k+TURN_TICKS. Window 0 is decided at edge k+TURN_TICKS+WIN_TICKS.
- R3: Windows follow each other with no gap, each exactly WIN_TICKS cycles. A frame of n bits raises `done` after edge k+TURN_TICKS+n*WIN_TICKS, and `busy` stays high until then.
- R4: A window decodes as one only when its edge count is strictly greater than ONE_THRESH. A count equal to ONE_THRESH decodes as zero.
- R5: In receive mode (`ack_mode`=0), the bit of window i is placed at `rx_word` bit i (LSB-first). Bits at and above n are zero.
- R6: A receive-mode start with `bit_count` of 0 or above MAX_BITS is rejected. At the next edge `done` and `bad_len` rise, `rx_word` is zero, and `busy` never rises.
- R7: In acknowledge mode (`ack_mode`=1), the first window that decodes as one ends the search. `ack_hit` rises with `ack_pos` set to that window index, and `done` rises at edge k+TURN_TICKS+(index+1)*WIN_TICKS. Later windows and `bit_count` have no effect.
- R8: If none of the ACK_WINDOWS windows decodes as one, `done` and `ack_timeout` rise after the last window. A one in that last window gives `ack_hit` and no timeout.
- R9: The per-window edge count saturates at 2**CNT_W-1 and never wraps.
- R10: `done` lasts one cycle. A start while `busy` is high, including the cycle whose edge raises `done`, is ignored.
- R11: `rx_word`, `ack_pos` and all flags hold their values until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing tick |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a reception (taken only when idle) |
| ack_mode | input | 1 | 0: receive `bit_count` bits; 1: search for an acknowledge bit |
| bit_count | input | LEN_W | Number of bits to receive, 1..MAX_BITS |
| rx_in | input | 1 | Comparator output, asynchronous |
| busy | output | 1 | Reception in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rx_word | output | MAX_BITS | Received bits, LSB-first |
| bad_len | output | 1 | Last start had an invalid bit count |
| ack_hit | output | 1 | Acknowledge bit found |
| ack_timeout | output | 1 | No acknowledge bit within the search span |
| ack_pos | output | POS_W | Window index of the acknowledge bit |

## Verification
Two functions can fall in the same cycle. In acknowledge mode, a one-bit found in the final window coincides with the timeout decision. The bench places a burst only in that last window and expects `ack_hit` with no timeout. The end of a frame can also coincide with a new start. The bench drives `start` so that it is sampled at the very edge that raises `done`, then expects `busy` to stay low afterwards and the received word to be unchanged.

// File: rtl/ecr_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the edge-count receiver.
package ecr_pkg;

    // Timing phase of the window timer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TURN = 2'd1,
        PH_RUN  = 2'd2
    } phase_t;

    // Larger of two integers, for width derivation.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ecr_edge_counter.sv
`timescale 1ns/1ps
// Synchronises the comparator output, detects level changes and counts
// them with saturation. Assumes rx_in is asynchronous to clk; a clear
// has priority over an edge in the same cycle.
module ecr_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic             clear,
    output logic             edge_seen,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic s_meta, s_sync, s_prev;

    // Two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_meta <= rx_in;
            s_sync <= s_meta;
            s_prev <= s_sync;
        end
    end

    assign edge_seen = s_sync ^ s_prev;

    // Saturating edge count, cleared at window boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)                             count <= '0;
        else if (clear)                         count <= '0;
        else if (edge_seen && count != CNT_MAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/ecr_window_timer.sv
`timescale 1ns/1ps
// Generates the turnaround delay and the fixed bit windows. Assumes
// TURN_TICKS and WIN_TICKS are at least 2. Each window boundary is
// derived from the previous one, so no drift accumulates.
module ecr_window_timer
    import ecr_pkg::*;
#(
    parameter int TURN_TICKS = 495,
    parameter int WIN_TICKS  = 142
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic halt,
    output logic in_window,
    output logic win_end
);
    localparam int TW = $clog2(max2(TURN_TICKS, WIN_TICKS) + 1);
    localparam logic [TW-1:0] TURN_LAST = TW'(TURN_TICKS - 1);
    localparam logic [TW-1:0] WIN_LAST  = TW'(WIN_TICKS - 1);

    phase_t        phase_q;
    logic [TW-1:0] tick_q;

    // Phase sequencing: idle, turnaround, then back-to-back windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            tick_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (launch) begin
                    phase_q <= PH_TURN;
                    tick_q  <= '0;
                end
                PH_TURN: if (tick_q == TURN_LAST) begin
                    phase_q <= PH_RUN;
                    tick_q  <= '0;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
                PH_RUN: if (halt) begin
                    phase_q <= PH_IDLE;
                    tick_q  <= '0;
                end else if (tick_q == WIN_LAST) begin
                    tick_q <= '0;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
                default: begin
                    phase_q <= PH_IDLE;
                    tick_q  <= '0;
                end
            endcase
        end
    end

    assign in_window = (phase_q == PH_RUN);
    assign win_end   = in_window && (tick_q == WIN_LAST);
endmodule

// File: rtl/edge_count_rx.sv
`timescale 1ns/1ps
// Subcarrier edge-count bit receiver. After a start it waits TURN_TICKS
// cycles, then decides one bit per WIN_TICKS-cycle window by comparing
// the window's edge count with ONE_THRESH. Receive mode packs bit_count
// bits LSB-first; acknowledge mode searches up to ACK_WINDOWS windows
// for the first one. Assumes ONE_THRESH < 2**CNT_W - 1.
module edge_count_rx
    import ecr_pkg::*;
#(
    parameter int TURN_TICKS  = 495,
    parameter int WIN_TICKS   = 142,
    parameter int ONE_THRESH  = 20,
    parameter int CNT_W       = 8,
    parameter int MAX_BITS    = 32,
    parameter int ACK_WINDOWS = 80,
    parameter int LEN_W       = $clog2(MAX_BITS) + 1,
    parameter int POS_W       = $clog2(ACK_WINDOWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                ack_mode,
    input  logic [LEN_W-1:0]    bit_count,
    input  logic                rx_in,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_word,
    output logic                bad_len,
    output logic                ack_hit,
    output logic                ack_timeout,
    output logic [POS_W-1:0]    ack_pos
);
    localparam int IDX_W = $clog2(max2(MAX_BITS, ACK_WINDOWS) + 1);
    localparam logic [CNT_W-1:0] THR     = CNT_W'(ONE_THRESH);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS);

    logic                in_window, win_end, cnt_clear, edge_seen;
    logic [CNT_W-1:0]    edge_cnt;
    logic                busy_q, mode_q, done_q, bad_q, hit_q, tmo_q;
    logic [LEN_W-1:0]    len_q;
    logic [IDX_W-1:0]    idx_q;
    logic [MAX_BITS-1:0] word_q;
    logic [POS_W-1:0]    pos_q;
    logic                len_ok, accept, launch, bit_one, last_bit, last_win, finish;

    assign cnt_clear = !in_window || win_end;

    ecr_edge_counter #(.CNT_W(CNT_W)) u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_in     (rx_in),
        .clear     (cnt_clear),
        .edge_seen (edge_seen),
        .count     (edge_cnt)
    );

    ecr_window_timer #(.TURN_TICKS(TURN_TICKS), .WIN_TICKS(WIN_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .halt      (finish),
        .in_window (in_window),
        .win_end   (win_end)
    );

    // Start qualification and per-window decision terms.
    always_comb begin
        len_ok   = (bit_count != '0) && (bit_count <= LEN_MAX);
        accept   = start && !busy_q;
        launch   = accept && (ack_mode || len_ok);
        bit_one  = (edge_cnt > THR);
        last_bit = (32'(idx_q) == 32'(len_q) - 32'd1);
        last_win = (32'(idx_q) == ACK_WINDOWS - 1);
        finish   = busy_q && win_end && (mode_q ? (bit_one || last_win) : last_bit);
    end

    // Operation control: accept, collect or search, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            mode_q <= 1'b0;
            len_q  <= '0;
            idx_q  <= '0;
            word_q <= '0;
            done_q <= 1'b0;
            bad_q  <= 1'b0;
            hit_q  <= 1'b0;
            tmo_q  <= 1'b0;
            pos_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                mode_q <= ack_mode;
                len_q  <= bit_count;
                idx_q  <= '0;
                word_q <= '0;
                bad_q  <= 1'b0;
                hit_q  <= 1'b0;
                tmo_q  <= 1'b0;
                pos_q  <= '0;
                if (launch) begin
                    busy_q <= 1'b1;
                end else begin
                    done_q <= 1'b1;
                    bad_q  <= 1'b1;
                end
            end else if (busy_q && win_end) begin
                idx_q <= idx_q + 1'b1;
                if (!mode_q) begin
                    word_q <= word_q | (MAX_BITS'(bit_one) << idx_q);
                end else if (bit_one) begin
                    hit_q <= 1'b1;
                    pos_q <= idx_q[POS_W-1:0];
                end else if (last_win) begin
                    tmo_q <= 1'b1;
                end
                if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy        = busy_q;
    assign done        = done_q;
    assign rx_word     = word_q;
    assign bad_len     = bad_q;
    assign ack_hit     = hit_q;
    assign ack_timeout = tmo_q;
    assign ack_pos     = pos_q;
endmodule

// File: rtl/ecr_checker.sv
`timescale 1ns/1ps
// Property checker for edge_count_rx, attached by bind below.
module ecr_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              bad_len,
    input logic              ack_hit,
    input logic              ack_timeout,
    input logic [DATA_W-1:0] rx_word,
    input logic              edge_seen,
    input logic              cnt_clear,
    input logic [CNT_W-1:0]  edge_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_not_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    p_hit_or_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_hit && ack_timeout));

    p_reject_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_len |-> (!busy && rx_word == '0 && !ack_hit && !ack_timeout));

    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_cnt == CMAX && edge_seen && !cnt_clear) |=> (edge_cnt == CMAX));

    p_results_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(rx_word) && $stable(ack_hit)
                               && $stable(ack_timeout) && $stable(bad_len)));
endmodule

bind edge_count_rx ecr_checker #(.DATA_W(MAX_BITS), .CNT_W(CNT_W)) u_ecr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .bad_len     (bad_len),
    .ack_hit     (ack_hit),
    .ack_timeout (ack_timeout),
    .rx_word     (rx_word),
    .edge_seen   (edge_seen),
    .cnt_clear   (cnt_clear),
    .edge_cnt    (edge_cnt)
);

// File: tb/edge_count_rx_bench.sv
`timescale 1ns/1ps
// Bench: small timing configuration, sweeps over frame lengths and
// burst sizes, expected values computed arithmetically.
module edge_count_rx_bench;
    localparam int TURN = 10;
    localparam int WIN  = 24;
    localparam int THR  = 5;
    localparam int CW   = 3;
    localparam int MAXB = 32;
    localparam int ACKW = 6;
    localparam int LW   = $clog2(MAXB) + 1;
    localparam int PW   = $clog2(ACKW);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            ack_mode = 1'b0;
    logic [LW-1:0]   bit_count = '0;
    logic            rx_in = 1'b0;
    logic            busy, done, bad_len, ack_hit, ack_timeout;
    logic [MAXB-1:0] rx_word;
    logic [PW-1:0]   ack_pos;

    int checks = 0;
    int errors = 0;
    int ew[0:39];
    int done_at, done_n;
    logic busy_first, busy_last;

    always #4 clk = ~clk;

    edge_count_rx #(
        .TURN_TICKS(TURN), .WIN_TICKS(WIN), .ONE_THRESH(THR),
        .CNT_W(CW), .MAX_BITS(MAXB), .ACK_WINDOWS(ACKW)
    ) u_edge_count_rx (
        .clk(clk), .rst_n(rst_n), .start(start), .ack_mode(ack_mode),
        .bit_count(bit_count), .rx_in(rx_in), .busy(busy), .done(done),
        .rx_word(rx_word), .bad_len(bad_len), .ack_hit(ack_hit),
        .ack_timeout(ack_timeout), .ack_pos(ack_pos)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Runs one operation; toggles rx_in ew[w] times mid-window w.
    // extra_m >= 0 re-asserts start at that negedge (must be ignored).
    task automatic frame(input logic am, input int n, input int last_m, input int extra_m);
        @(negedge clk);
        start = 1'b1; ack_mode = am; bit_count = LW'(n);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        done_at = -1; done_n = 0;
        busy_first = busy;
        for (int m = 0; m <= last_m; m++) begin
            if (done) begin
                done_n++;
                if (done_at < 0) done_at = m;
            end
            busy_last = busy;
            if (m >= TURN) begin
                int w, off;
                w = (m - TURN) / WIN;
                off = (m - TURN) % WIN;
                if (w < 40 && off >= 4 && off < 4 + ew[w]) rx_in = ~rx_in;
            end
            if (m == extra_m) begin
                start = 1'b1; ack_mode = ~am; bit_count = LW'(1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    function automatic logic [MAXB-1:0] exp_word(input int n);
        logic [MAXB-1:0] r = '0;
        for (int i = 0; i < n; i++) if (ew[i] > THR) r[i] = 1'b1;
        return r;
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int e;
        logic [MAXB-1:0] held;
        for (int i = 0; i < 40; i++) ew[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 word", rx_word, 0);
        chk("R1 flags", {bad_len, ack_hit, ack_timeout}, 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R9 sweep over every frame length
        for (int n = 1; n <= MAXB; n++) begin
            for (int i = 0; i < 40; i++) ew[i] = (i * 5 + n * 3) % 17;
            e = TURN + n * WIN;
            frame(1'b0, n, e + 2, -1);
            chk($sformatf("R3 done cycle n=%0d", n), done_at, e);
            chk($sformatf("R10 done pulses n=%0d", n), done_n, 1);
            chk($sformatf("R5 word n=%0d", n), rx_word, exp_word(n));
            chk($sformatf("R6 flags n=%0d", n), {bad_len, ack_hit, ack_timeout}, 0);
        end

        // R4 exact threshold decodes zero, one above decodes one
        for (int i = 0; i < 40; i++) ew[i] = 0;
        ew[0] = THR; ew[1] = THR + 1; ew[2] = 0;
        frame(1'b0, 3, TURN + 3 * WIN + 2, -1);
        chk("R4 threshold", rx_word, 32'h2);
        // R2 single bit: first decision after the turnaround
        ew[0] = 9;
        frame(1'b0, 1, TURN + WIN + 2, -1);
        chk("R2 first window", done_at, TURN + WIN);
        chk("R2 first bit", rx_word, 32'h1);
        // R9 saturation: 12 and 13 edges would wrap to 4 and 5
        ew[0] = 12; ew[1] = 13; ew[2] = 16;
        frame(1'b0, 3, TURN + 3 * WIN + 2, -1);
        chk("R9 no wrap", rx_word, 32'h7);

        // R6 invalid lengths
        for (int k = 0; k < 3; k++) begin
            int bn;
            bn = (k == 0) ? 0 : ((k == 1) ? MAXB + 1 : (1 << LW) - 1);
            frame(1'b0, bn, 6, -1);
            chk($sformatf("R6 reject done len=%0d", bn), done_at, 0);
            chk($sformatf("R6 reject flag len=%0d", bn), bad_len, 1);
            chk($sformatf("R6 reject word len=%0d", bn), rx_word, 0);
            chk($sformatf("R6 reject busy len=%0d", bn), {busy_first, busy_last}, 0);
        end

        // R7 R8 acknowledge search, hit in each window
        for (int p = 0; p < ACKW; p++) begin
            for (int i = 0; i < 40; i++) ew[i] = (i > p) ? 9 : 0;
            ew[p] = 8;
            e = TURN + (p + 1) * WIN;
            frame(1'b1, 0, e + 2, -1);
            chk($sformatf("R7 ack done p=%0d", p), done_at, e);
            chk($sformatf("R7 ack pos p=%0d", p), {ack_hit, 29'(ack_pos)}, {1'b1, 29'(p)});
            chk($sformatf("R8 no timeout p=%0d", p), ack_timeout, 0);
            chk($sformatf("R7 word untouched p=%0d", p), rx_word, 0);
        end
        // R8 timeout, with sub-threshold noise
        for (int i = 0; i < 40; i++) ew[i] = (i < ACKW) ? THR : 9;
        e = TURN + ACKW * WIN;
        frame(1'b1, 0, e + 4, -1);
        chk("R8 timeout done", done_at, e);
        chk("R8 timeout flag", {ack_timeout, ack_hit}, 2'b10);

        // R10 start while busy (mid-frame) is ignored
        for (int i = 0; i < 40; i++) ew[i] = (i % 2 == 0) ? 10 : 1;
        e = TURN + 4 * WIN;
        frame(1'b0, 4, e + 3, TURN + WIN + 3);
        chk("R10 mid start done", done_at, e);
        chk("R10 mid start word", rx_word, 32'h5);
        // R10 start sampled at the edge that raises done is ignored
        frame(1'b0, 4, e + 3, e - 1);
        chk("R10 edge start pulses", done_n, 1);
        chk("R10 edge start idle", busy_last, 0);
        chk("R10 edge start word", rx_word, 32'h5);

        // R11 results held while idle with rx_in toggling
        held = rx_word;
        for (int i = 0; i < 30; i++) begin
            rx_in = ~rx_in;
            @(negedge clk);
        end
        chk("R11 word held", rx_word, held);
        chk("R11 flags held", {bad_len, ack_hit, ack_timeout, done, busy}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule